// File: doc/BRIEF.md
# MFM Sector Sync Bit Aligner

This block sits behind a floppy read-channel sampler and watches the recovered serial bitstream for the four-word sector sync mark `0xAAAA 0xAAAA 0x4489 0x4489`. The mark may land at any of eight bit offsets relative to byte boundaries. When the block finds it, it pulses a flag, reports the offset, and then packs the bits that follow into 16-bit words, aligned to the sync, for a number of words the user sets. Sectors on one track can sit at different offsets. The block therefore re-establishes alignment for every sector. It does not assume the offset it found on the first sector.

Matching runs on a 64-bit history register that is compared with the full mark on every accepted bit, so every offset is covered at once. The offset comes from a three-bit position counter that is cleared at the start of each track. A state machine has three states:

- **HUNT**: any offset is accepted.
- **EMIT**: words are being delivered.
- **EXPECT**: a guard window after a sector ends. In this state only a sync at the previous sector's offset is accepted.

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| HUNT→EMIT | HUNT | EMIT | Sync seen, word budget not zero |
| HUNT→EXPECT | HUNT | EXPECT | Sync seen, zero-word budget |
| EMIT→EMIT | EMIT | EMIT | Relock on a new sync |
| EMIT→EXPECT | EMIT | EXPECT | Last word delivered |
| EXPECT→EMIT / EXPECT→EXPECT | EXPECT | EMIT or EXPECT | Sync at the previous offset |
| EXPECT→HUNT | EXPECT | HUNT | Guard window spent |
| any→HUNT | any state | HUNT | Track start |

A sector counter tracks the accepted syncs on the current track.

Top module: `mfm_sync_aligner`

## Requirements
- R1: The full 64-bit mark is detected at any bit offset. `sync_found` is high for exactly the one cycle that follows the clock edge capturing the mark's last bit.
- R2: `sync_shift` equals the index of the mark's first bit, counted in valid bits since the last track start, modulo 8. It changes only together with `sync_found` or on a track start, and holds otherwise.
- R3: After an accepted sync, the next `word_count` valid bits are packed into 16-bit words, first received bit in bit 15. `word_valid` pulses for one cycle after the edge that captures each word's 16th bit.
- R4: Only cycles with `bit_valid` high advance matching, packing and position counting. Idle cycles between bits have no effect.
- R5: A sync that completes while words are being delivered aborts the sector and relocks at the new offset. The unfinished partial word is dropped, and a fresh `word_count` budget starts.
- R6: After the last word of a sector, a guard window of `GUARD_BITS` valid bits follows. In that window a sync at the previous offset is accepted, and a sync at any other offset is ignored: no pulse, no words, no count change.
- R7: Once the guard window runs out, the block accepts a sync at any offset again.
- R8: `sector_count` rises by one for each accepted sync and saturates at its maximum. `sync_found` still pulses when it saturates.
- R9: `track_start` clears `sector_count`, the bit position, the offset and the 64-bit history, and returns the block to HUNT. A bit presented in the same cycle is discarded.
- R10: A `word_count` of zero delivers no words after a sync and goes straight into the guard window.
- R11: After reset all outputs are zero and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track_start | input | 1 | Restart of a track (clears position and count) |
| bit_in | input | 1 | Recovered serial bit |
| bit_valid | input | 1 | `bit_in` carries a new bit this cycle |
| word_count | input | WC_W | Words to deliver per sector, sampled at each sync |
| sync_found | output | 1 | One-cycle pulse per accepted sync |
| sync_shift | output | 3 | Bit offset of the last accepted sync |
| sector_count | output | CNT_W | Accepted syncs since the track start, saturating |
| word_out | output | WORD_W | Aligned sector word |
| word_valid | output | 1 | `word_out` is new this cycle |

## Verification
Every result is due one cycle after the edge that captures the bit causing it:

- `sync_found` appears after the mark's last bit.
- `word_valid` appears after each word's 16th bit.
- `sector_count` clears after the edge that sees `track_start`.

The bench drives bits on falling edges and samples outputs one nanosecond after each rising edge. It stamps every pulse with its own count of bits sent, so it can compare the stamp with the exact bit number the requirement predicts: the mark start plus 64 for a sync, and a further 16 for the first word. The bench keeps a copy of every bit it sent and builds the expected words from that copy, so words delivered before a relock are checked as well.

// File: rtl/mfm_align_pkg.sv
`timescale 1ns/1ps
package mfm_align_pkg;

    // Width of the sync mark and the mark itself
    localparam int SYNC_W = 64;
    localparam logic [SYNC_W-1:0] SYNC_MARK = 64'hAAAA_AAAA_4489_4489;

    // Offsets are reported modulo 8
    localparam int OFFSETS = 8;
    localparam int POS_W   = $clog2(OFFSETS);

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_EXPECT = 2'd2
    } align_state_e;

endpackage

// File: rtl/mfm_sync_matcher.sv
`timescale 1ns/1ps
module mfm_sync_matcher #(
    parameter int                SYNC_W  = 64,
    parameter logic [SYNC_W-1:0] PATTERN = 64'hAAAA_AAAA_4489_4489,
    parameter int                POS_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_in,
    input  logic             bit_valid,
    output logic             hit,
    output logic [POS_W-1:0] hit_shift
);

    logic [SYNC_W-1:0] history;
    logic [POS_W-1:0]  pos;
    logic [SYNC_W-1:0] history_next;

    assign history_next = {history[SYNC_W-2:0], bit_in};

    // Mark complete on this bit; position of its first bit modulo 2^POS_W
    assign hit       = bit_valid && !clear && (history_next == PATTERN);
    assign hit_shift = pos - POS_W'(SYNC_W - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            history <= '0;
            pos     <= '0;
        end else if (clear) begin
            history <= '0;
            pos     <= '0;
        end else if (bit_valid) begin
            history <= history_next;
            pos     <= pos + POS_W'(1);
        end
    end

    // R4: idle cycles leave the bit position untouched
    a_r4_pos_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !clear) |=> $stable(pos));

    // R9: a cleared track restarts at position zero
    a_r9_pos_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pos == '0));

endmodule

// File: rtl/mfm_word_packer.sv
`timescale 1ns/1ps
module mfm_word_packer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              word_tick,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  fill;
    logic [WORD_W-2:0] acc;

    assign word_tick = shift_en && !clear && (fill == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill       <= '0;
            acc        <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (clear) begin
                fill <= '0;
            end else if (shift_en) begin
                if (fill == LAST) begin
                    word_out   <= {acc, bit_in};
                    word_valid <= 1'b1;
                    fill       <= '0;
                end else begin
                    acc  <= {acc[WORD_W-3:0], bit_in};
                    fill <= fill + CNT_W'(1);
                end
            end
        end
    end

    // R3: a delivered word is a single-cycle strobe
    a_r3_word_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R5: a relock drops the partial word, so the next fill starts empty
    a_r5_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill == '0) && !word_valid);

endmodule

// File: rtl/mfm_align_fsm.sv
`timescale 1ns/1ps
module mfm_align_fsm
    import mfm_align_pkg::*;
#(
    parameter int WC_W       = 8,
    parameter int CNT_W      = 8,
    parameter int GUARD_BITS = 256,
    parameter int SH_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_start,
    input  logic              bit_valid,
    input  logic              hit,
    input  logic [SH_W-1:0]   hit_shift,
    input  logic              word_tick,
    input  logic [WC_W-1:0]   word_count,
    output align_state_e      state,
    output logic              pack_en,
    output logic              pack_clear,
    output logic              sync_found,
    output logic [SH_W-1:0]   sync_shift,
    output logic [CNT_W-1:0]  sector_count
);

    localparam int GW = $clog2(GUARD_BITS + 1);
    localparam logic [GW-1:0]    GUARD_LOAD = GW'(GUARD_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};

    align_state_e     state_next;
    logic [WC_W-1:0]  words_left, words_next;
    logic [GW-1:0]    guard, guard_next;
    logic             accept;

    // In the guard window only the previous offset is honoured
    assign accept     = hit && ((state != ST_EXPECT) || (hit_shift == sync_shift));
    assign pack_en    = (state == ST_EMIT) && bit_valid && !accept;
    assign pack_clear = accept || track_start;

    // Next-state logic
    always_comb begin
        state_next = state;
        words_next = words_left;
        guard_next = guard;
        if (track_start) begin
            state_next = ST_HUNT;
            words_next = '0;
            guard_next = '0;
        end else if (accept) begin
            if (word_count == '0) begin
                state_next = ST_EXPECT;
                guard_next = GUARD_LOAD;
            end else begin
                state_next = ST_EMIT;
                words_next = word_count;
            end
        end else begin
            unique case (state)
                ST_HUNT: begin
                    state_next = ST_HUNT;
                end
                ST_EMIT: begin
                    if (word_tick) begin
                        if (words_left == WC_W'(1)) begin
                            state_next = ST_EXPECT;
                            guard_next = GUARD_LOAD;
                            words_next = '0;
                        end else begin
                            words_next = words_left - WC_W'(1);
                        end
                    end
                end
                ST_EXPECT: begin
                    if (bit_valid) begin
                        if (guard <= GW'(1)) begin
                            state_next = ST_HUNT;
                            guard_next = '0;
                        end else begin
                            guard_next = guard - GW'(1);
                        end
                    end
                end
                default: begin
                    state_next = ST_HUNT;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HUNT;
            words_left <= '0;
            guard      <= '0;
        end else begin
            state      <= state_next;
            words_left <= words_next;
            guard      <= guard_next;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_found   <= 1'b0;
            sync_shift   <= '0;
            sector_count <= '0;
        end else begin
            sync_found <= accept;
            if (track_start) begin
                sync_shift   <= '0;
                sector_count <= '0;
            end else if (accept) begin
                sync_shift <= hit_shift;
                if (sector_count != CNT_MAX) begin
                    sector_count <= sector_count + CNT_W'(1);
                end
            end
        end
    end

    // R6: a mark at a foreign offset inside the guard window is dropped
    a_r6_foreign_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPECT && hit && hit_shift != sync_shift) |=> !sync_found);

    // R8: the count never falls except on a track start
    a_r8_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !track_start |=> (sector_count >= $past(sector_count)));

    // R9: track start clears the count and returns to hunting
    a_r9_track_clear: assert property (@(posedge clk) disable iff (!rst_n)
        track_start |=> (sector_count == '0) && (state == ST_HUNT));

    // R2: the reported offset only moves with a sync pulse
    a_r2_shift_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_found && !$past(track_start)) |-> $stable(sync_shift));

endmodule

// File: rtl/mfm_sync_aligner.sv
`timescale 1ns/1ps
module mfm_sync_aligner
    import mfm_align_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int WC_W       = 8,
    parameter int CNT_W      = 8,
    parameter int GUARD_BITS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_start,
    input  logic              bit_in,
    input  logic              bit_valid,
    input  logic [WC_W-1:0]   word_count,
    output logic              sync_found,
    output logic [POS_W-1:0]  sync_shift,
    output logic [CNT_W-1:0]  sector_count,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    logic             hit;
    logic [POS_W-1:0] hit_shift;
    logic             pack_en;
    logic             pack_clear;
    logic             word_tick;
    align_state_e     state;

    mfm_sync_matcher #(
        .SYNC_W  (SYNC_W),
        .PATTERN (SYNC_MARK),
        .POS_W   (POS_W)
    ) u_matcher (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (track_start),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .hit       (hit),
        .hit_shift (hit_shift)
    );

    mfm_align_fsm #(
        .WC_W       (WC_W),
        .CNT_W      (CNT_W),
        .GUARD_BITS (GUARD_BITS),
        .SH_W       (POS_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .track_start  (track_start),
        .bit_valid    (bit_valid),
        .hit          (hit),
        .hit_shift    (hit_shift),
        .word_tick    (word_tick),
        .word_count   (word_count),
        .state        (state),
        .pack_en      (pack_en),
        .pack_clear   (pack_clear),
        .sync_found   (sync_found),
        .sync_shift   (sync_shift),
        .sector_count (sector_count)
    );

    mfm_word_packer #(
        .WORD_W (WORD_W)
    ) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pack_clear),
        .shift_en   (pack_en),
        .bit_in     (bit_in),
        .word_tick  (word_tick),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    // R3: words only come out of a sector being delivered
    a_r3_word_in_emit: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($past(state) == ST_EMIT));

    // R1: a sync pulse never coincides with a word strobe
    a_r1_sync_not_word: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |-> !word_valid);

endmodule

// File: tb/mfm_sync_aligner_bench.sv
`timescale 1ns/1ps
module mfm_sync_aligner_bench;

    localparam int GUARD = 256;
    localparam int HMAX  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        track_start = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_valid = 1'b0;
    logic [7:0]  word_count = 8'd0;
    logic        sync_found;
    logic [2:0]  sync_shift;
    logic [7:0]  sector_count;
    logic [15:0] word_out;
    logic        word_valid;

    mfm_sync_aligner u_mfm_sync_aligner (
        .clk          (clk),
        .rst_n        (rst_n),
        .track_start  (track_start),
        .bit_in       (bit_in),
        .bit_valid    (bit_valid),
        .word_count   (word_count),
        .sync_found   (sync_found),
        .sync_shift   (sync_shift),
        .sector_count (sector_count),
        .word_out     (word_out),
        .word_valid   (word_valid)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int tb_pos = 0;
    logic hist [HMAX];

    int          sync_n = 0;
    int          first_sync_pos = 0;
    logic [2:0]  shift_seen = '0;
    int          word_n = 0;
    int          first_word_pos = 0;
    logic [15:0] words [16];

    // Sample outputs 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (sync_found) begin
            if (sync_n == 0) first_sync_pos = tb_pos;
            sync_n++;
            shift_seen = sync_shift;
        end
        if (word_valid) begin
            if (word_n == 0) first_word_pos = tb_pos;
            if (word_n < 16) words[word_n] = word_out;
            word_n++;
        end
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit gap);
        @(negedge clk);
        bit_in    = b;
        bit_valid = 1'b1;
        if (tb_pos < HMAX) hist[tb_pos] = b;
        tb_pos++;
        if (gap) begin
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic send_word(input logic [15:0] w, input bit gap);
        for (int i = 15; i >= 0; i--) send_bit(w[i], gap);
    endtask

    task automatic send_sync(input bit gap);
        send_word(16'hAAAA, gap);
        send_word(16'hAAAA, gap);
        send_word(16'h4489, gap);
        send_word(16'h4489, gap);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
    endtask

    task automatic pad_to(input int sh);
        while ((tb_pos % 8) != sh) send_bit(1'b0, 1'b0);
    endtask

    task automatic clear_log;
        @(negedge clk);
        bit_valid = 1'b0;
        sync_n = 0;
        word_n = 0;
    endtask

    task automatic new_track;
        @(negedge clk);
        track_start = 1'b1;
        bit_valid   = 1'b1;
        bit_in      = 1'b1;
        @(negedge clk);
        track_start = 1'b0;
        bit_valid   = 1'b0;
        tb_pos      = 0;
    endtask

    function automatic logic [15:0] hw(input int s);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) r = {r[14:0], hist[s + i]};
        return r;
    endfunction

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R11 sync_found", sync_found, 0);
        chk("R11 word_valid", word_valid, 0);
        chk("R11 sector_count", sector_count, 0);
        chk("R11 sync_shift", sync_shift, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_aligned;
        word_count = 8'd3;
        new_track();
        clear_log();
        send_sync(1'b0);
        send_word(16'h1234, 1'b0);
        send_word(16'h5678, 1'b0);
        send_word(16'h9ABC, 1'b0);
        zeros(8);
        idle(2);
        chk("R1 one sync", sync_n, 1);
        chk("R1 pulse after last mark bit", first_sync_pos, 64);
        chk("R2 shift 0", shift_seen, 0);
        chk("R3 word count", word_n, 3);
        chk("R3 first word timing", first_word_pos, 80);
        chk("R3 word0", words[0], 16'h1234);
        chk("R3 word1", words[1], 16'h5678);
        chk("R3 word2", words[2], 16'h9ABC);
        chk("R8 count 1", sector_count, 1);
    endtask

    task automatic t_shift7_gaps;
        word_count = 8'd2;
        new_track();
        clear_log();
        zeros(7);
        send_sync(1'b1);
        send_word(16'h0F0F, 1'b1);
        send_word(16'h1357, 1'b1);
        idle(2);
        chk("R2 shift 7", shift_seen, 7);
        chk("R4 pulse after gapped mark", first_sync_pos, 71);
        chk("R4 two words", word_n, 2);
        chk("R4 word0", words[0], 16'h0F0F);
        chk("R4 word1", words[1], 16'h1357);
    endtask

    task automatic t_expect;
        int s;
        clear_log();
        zeros(3);
        chk("R6 foreign offset differs", (tb_pos % 8) != 7, 1);
        send_sync(1'b0);
        zeros(2);
        idle(2);
        chk("R6 foreign sync ignored", sync_n, 0);
        chk("R6 no words", word_n, 0);
        chk("R6 count held", sector_count, 1);
        pad_to(7);
        s = tb_pos;
        send_sync(1'b0);
        send_word(16'h2468, 1'b0);
        send_word(16'h1359, 1'b0);
        idle(2);
        chk("R6 same offset accepted", sync_n, 1);
        chk("R6 pulse timing", first_sync_pos, s + 64);
        chk("R6 shift", shift_seen, 7);
        chk("R6 word0", words[0], 16'h2468);
        chk("R6 count 2", sector_count, 2);
    endtask

    task automatic t_hunt;
        clear_log();
        zeros(GUARD + 20);
        pad_to(2);
        word_count = 8'd1;
        send_sync(1'b0);
        send_word(16'h7E81, 1'b0);
        idle(2);
        chk("R7 any offset after window", sync_n, 1);
        chk("R7 shift 2", shift_seen, 2);
        chk("R7 word", words[0], 16'h7E81);
        chk("R7 count 3", sector_count, 3);
    endtask

    task automatic t_abort;
        int s1;
        int s2;
        word_count = 8'd8;
        new_track();
        clear_log();
        s1 = tb_pos;
        send_sync(1'b0);
        send_word(16'h1111, 1'b0);
        for (int i = 15; i >= 7; i--) send_bit(((16'h2222 >> i) & 16'h1) != 0, 1'b0);
        pad_to(5);
        s2 = tb_pos;
        send_sync(1'b0);
        send_word(16'h3333, 1'b0);
        send_word(16'h4444, 1'b0);
        send_word(16'h5555, 1'b0);
        send_word(16'h6666, 1'b0);
        idle(2);
        chk("R5 two syncs", sync_n, 2);
        chk("R5 relock shift", shift_seen, 5);
        chk("R5 count", sector_count, 2);
        chk("R5 words total", word_n, 9);
        for (int k = 0; k < 5; k++) chk("R5 pre-relock word", words[k], hw(s1 + 64 + 16 * k));
        chk("R5 partial dropped", (s1 + 64 + 16 * 5 + 15) >= (s2 + 64), 1);
        chk("R5 post word0", words[5], 16'h3333);
        chk("R5 post word3", words[8], 16'h6666);
    endtask

    task automatic t_zero_words;
        word_count = 8'd0;
        new_track();
        clear_log();
        send_sync(1'b0);
        zeros(16);
        idle(2);
        chk("R10 sync seen", sync_n, 1);
        chk("R10 no words", word_n, 0);
        pad_to(0);
        send_sync(1'b0);
        idle(2);
        chk("R10 guard window entered, same offset", sync_n, 2);
        zeros(3);
        send_sync(1'b0);
        idle(2);
        chk("R10 guard window foreign offset", sync_n, 2);
    endtask

    task automatic t_saturate;
        word_count = 8'd0;
        new_track();
        clear_log();
        for (int i = 0; i < 260; i++) send_sync(1'b0);
        idle(2);
        chk("R8 pulses while saturated", sync_n, 260);
        chk("R8 saturates", sector_count, 255);
    endtask

    task automatic t_track_clear;
        new_track();
        idle(1);
        chk("R9 count cleared", sector_count, 0);
        clear_log();
        zeros(3);
        send_sync(1'b0);
        idle(2);
        chk("R9 hunting after clear", sync_n, 1);
        chk("R9 position restarted", shift_seen, 3);
        chk("R9 count 1", sector_count, 1);
    endtask

    initial begin
        t_reset();
        t_aligned();
        t_shift7_gaps();
        t_expect();
        t_hunt();
        t_abort();
        t_zero_words();
        t_saturate();
        t_track_clear();
        idle(4);
        report();
        $finish;
    end

endmodule